// File: doc/BRIEF.md
# Register-Mapped 16-bit Multiply-Accumulate Unit

This peripheral sits on a simple synchronous register bus and multiplies or multiply-accumulates two 16-bit words. Software first writes operand A to one of four addresses. The address it chooses sets the operation: unsigned or signed, and multiply or accumulate. Software then writes operand B. That write starts the operation.

The 32-bit result is read back as two 16-bit words. A third word, the extension word, carries the sign or the carry of the result, and its meaning depends on the mode. Software can preset the accumulator by writing the low result word. A plain multiply leaves the accumulator cleared, so the next accumulate starts from zero.

All accesses are 16-bit words. Address bit 0 is ignored. The word index `addr[3:1]` selects the register as follows:

| Index | Register |
|---|---|
| 0 | Operand A, unsigned multiply |
| 1 | Operand A, signed multiply |
| 2 | Operand A, unsigned accumulate |
| 3 | Operand A, signed accumulate |
| 4 | Operand B |
| 5 | Low result word |
| 6 | High result word |
| 7 | Extension word |

Top module: `mulacc16`

## Requirements
- R1: A write to word index 0 to 3 latches operand A and sets the mode to that index. Mode bit 0 set means signed. Mode bit 1 set means accumulate.
- R2: A write to word index 4 latches operand B and starts the operation. Its result can be read in the cycle after the write. Address bit 0 plays no part in decoding.
- R3: In unsigned multiply mode, the result is the zero-extended 32-bit product. The extension word reads 0x0000.
- R4: In signed multiply mode, both operands are sign-extended. The result is the 32-bit two's-complement product. The extension word reads 0xFFFF when the product is negative and 0x0000 otherwise.
- R5: A plain multiply (mode bit 1 clear) clears the accumulator. A following accumulate therefore yields only its own product.
- R6: In unsigned accumulate mode, the zero-extended product is added to the 32-bit accumulator, and the result shows the new accumulator. The extension word reads 0x0001 when that addition carried out of bit 31 and 0x0000 otherwise.
- R7: In signed accumulate mode, the sign-extended product is added to the accumulator, and the result shows the new accumulator. The extension word reads 0xFFFF when result bit 31 is set and 0x0000 otherwise.
- R8: A write to word index 5 loads both the result and the accumulator. The value is sign-extended in the signed modes and zero-extended in the unsigned modes, and the stored carry is cleared.
- R9: A read of word index 0 to 3 returns operand A. A read of word index 4 returns operand B.
- R10: Writes to word index 6 or 7 have no effect on the result or the accumulator.
- R11: After reset, every register reads 0x0000 and the mode is unsigned multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte address; bits 3:1 select the register |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the addressed register, combinational |

## Verification
The assertions check these on every cycle:
- An operand A write records its mode.
- A plain multiply leaves the accumulator at zero.
- A preload makes the result equal to the accumulator.
- Writes to the high word and extension word leave the result and the accumulator untouched.
- The extension word only takes values that are legal for the current mode.

Only the bench's scenarios can show the arithmetic itself: signed and unsigned products, accumulation across several writes, the carry out of bit 31, sign- and zero-extended preloads, and the restart from zero after a plain multiply.

// File: rtl/mulacc16_pkg.sv
package mulacc16_pkg;
  localparam int ADDR_W = 4;
  localparam int IDX_W  = ADDR_W - 1;

  localparam logic [1:0] MODE_UMUL = 2'd0;
  localparam logic [1:0] MODE_SMUL = 2'd1;
  localparam logic [1:0] MODE_UMAC = 2'd2;
  localparam logic [1:0] MODE_SMAC = 2'd3;
  localparam int MODE_SGN_BIT = 0;
  localparam int MODE_ACC_BIT = 1;

  localparam logic [IDX_W-1:0] IDX_OPB   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_RESLO = 3'd5;
  localparam logic [IDX_W-1:0] IDX_RESHI = 3'd6;
  localparam logic [IDX_W-1:0] IDX_EXT   = 3'd7;
endpackage

// File: rtl/mulacc16_decode.sv
module mulacc16_decode
  import mulacc16_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_opa,
  output logic              wr_opb,
  output logic              wr_reslo
);
  always_comb begin
    idx      = addr[ADDR_W-1:1];
    wr_opa   = wr_en && !idx[IDX_W-1];
    wr_opb   = wr_en && (idx == IDX_OPB);
    wr_reslo = wr_en && (idx == IDX_RESLO);
  end
endmodule

// File: rtl/mulacc16_arith.sv
module mulacc16_arith #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic            sgn,
  input  logic [2*DW-1:0] acc,
  output logic [2*DW-1:0] prod,
  output logic [2*DW-1:0] sum,
  output logic            carry
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] ax, bx;
  logic [PW:0]   total;

  always_comb begin
    ax    = sgn ? {{DW{opa[DW-1]}}, opa} : {{DW{1'b0}}, opa};
    bx    = sgn ? {{DW{opb[DW-1]}}, opb} : {{DW{1'b0}}, opb};
    prod  = ax * bx;
    total = {1'b0, acc} + {1'b0, prod};
    sum   = total[PW-1:0];
    carry = total[PW];
  end
endmodule

// File: rtl/mulacc16_rdmux.sv
module mulacc16_rdmux
  import mulacc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  input  logic [2*DW-1:0]  res,
  input  logic [1:0]       mode,
  input  logic             carry,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] ext_word;

  always_comb begin
    if (mode[MODE_SGN_BIT])
      ext_word = {DW{res[2*DW-1]}};
    else if (mode[MODE_ACC_BIT])
      ext_word = {{(DW-1){1'b0}}, carry};
    else
      ext_word = '0;

    if (!idx[IDX_W-1]) begin
      rd_data = opa;
    end else begin
      unique case (idx)
        IDX_OPB:   rd_data = opb;
        IDX_RESLO: rd_data = res[DW-1:0];
        IDX_RESHI: rd_data = res[2*DW-1:DW];
        default:   rd_data = ext_word;
      endcase
    end
  end
endmodule

// File: rtl/mulacc16.sv
module mulacc16
  import mulacc16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data
);
  localparam int PW = 2 * DW;

  logic [IDX_W-1:0] idx;
  logic             wr_opa, wr_opb, wr_reslo;

  logic [DW-1:0] opa_q, opa_d, opb_q, opb_d;
  logic [1:0]    mode_q, mode_d;
  logic [PW-1:0] res_q, res_d, acc_q, acc_d;
  logic          carry_q, carry_d;

  logic [PW-1:0] prod, sum;
  logic          sum_carry;
  logic [PW-1:0] preload;

  mulacc16_decode u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .idx      (idx),
    .wr_opa   (wr_opa),
    .wr_opb   (wr_opb),
    .wr_reslo (wr_reslo)
  );

  mulacc16_arith #(.DW(DW)) u_arith (
    .opa   (opa_q),
    .opb   (wr_data),
    .sgn   (mode_q[MODE_SGN_BIT]),
    .acc   (acc_q),
    .prod  (prod),
    .sum   (sum),
    .carry (sum_carry)
  );

  mulacc16_rdmux #(.DW(DW)) u_rd (
    .idx     (idx),
    .opa     (opa_q),
    .opb     (opb_q),
    .res     (res_q),
    .mode    (mode_q),
    .carry   (carry_q),
    .rd_data (rd_data)
  );

  always_comb begin
    opa_d   = opa_q;
    opb_d   = opb_q;
    mode_d  = mode_q;
    res_d   = res_q;
    acc_d   = acc_q;
    carry_d = carry_q;
    preload = mode_q[MODE_SGN_BIT] ? {{DW{wr_data[DW-1]}}, wr_data}
                                   : {{DW{1'b0}}, wr_data};
    if (wr_opa) begin
      opa_d  = wr_data;
      mode_d = idx[1:0];
    end
    if (wr_opb) begin
      opb_d = wr_data;
      if (mode_q[MODE_ACC_BIT]) begin
        res_d   = sum;
        acc_d   = sum;
        carry_d = sum_carry && !mode_q[MODE_SGN_BIT];
      end else begin
        res_d   = prod;
        acc_d   = '0;
        carry_d = 1'b0;
      end
    end
    if (wr_reslo) begin
      res_d   = preload;
      acc_d   = preload;
      carry_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q   <= '0;
      opb_q   <= '0;
      mode_q  <= MODE_UMUL;
      res_q   <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (wr_en) begin
      opa_q   <= opa_d;
      opb_q   <= opb_d;
      mode_q  <= mode_d;
      res_q   <= res_d;
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end
endmodule

// File: rtl/mulacc16_checker.sv
module mulacc16_checker
  import mulacc16_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DW-1:0]     rd_data,
  input logic [1:0]        mode_q,
  input logic [2*DW-1:0]   res_q,
  input logic [2*DW-1:0]   acc_q
);
  logic [IDX_W-1:0] cidx;
  assign cidx = addr[ADDR_W-1:1];

  a_r1_mode_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cidx[IDX_W-1]) |=> (mode_q == $past(cidx[1:0])));

  a_r5_plain_clears_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cidx == IDX_OPB && !mode_q[MODE_ACC_BIT]) |=> (acc_q == '0));

  a_r3_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx == IDX_EXT && mode_q == MODE_UMUL) |-> (rd_data == '0));

  a_r6_ext_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx == IDX_EXT && mode_q == MODE_UMAC) |-> (rd_data[DW-1:1] == '0));

  a_r7_ext_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx == IDX_EXT && mode_q[MODE_SGN_BIT]) |-> (rd_data == '0 || rd_data == '1));

  a_r8_preload_match: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cidx == IDX_RESLO) |=> (res_q == acc_q));

  a_r10_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (cidx == IDX_RESHI || cidx == IDX_EXT)) |=> ($stable(res_q) && $stable(acc_q)));
endmodule

bind mulacc16 mulacc16_checker #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_data (rd_data),
  .mode_q  (mode_q),
  .res_q   (res_q),
  .acc_q   (acc_q)
);

// File: tb/mulacc16_bench.sv
module mulacc16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [15:0] m_opa, m_opb;
  logic [1:0]  m_mode;
  logic [31:0] m_res, m_acc;
  logic        m_carry;

  mulacc16 u_mulacc16 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
    longint pa, pb, p;
    logic [32:0] s;
    case (a[3:1])
      3'd0, 3'd1, 3'd2, 3'd3: begin m_opa = d; m_mode = a[2:1]; end
      3'd4: begin
        m_opb = d;
        pa = m_mode[0] ? longint'($signed(m_opa)) : longint'(m_opa);
        pb = m_mode[0] ? longint'($signed(d)) : longint'(d);
        p  = pa * pb;
        if (m_mode[1]) begin
          s = {1'b0, m_acc} + {1'b0, p[31:0]};
          m_acc = s[31:0]; m_res = s[31:0];
          m_carry = m_mode[0] ? 1'b0 : s[32];
        end else begin
          m_res = p[31:0]; m_acc = 32'h0; m_carry = 1'b0;
        end
      end
      3'd5: begin
        m_res = m_mode[0] ? {{16{d[15]}}, d} : {16'h0, d};
        m_acc = m_res; m_carry = 1'b0;
      end
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] exp_ext();
    case (m_mode)
      2'd0: return 16'h0000;
      2'd2: return {15'h0, m_carry};
      default: return m_res[31] ? 16'hFFFF : 16'h0000;
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
    addr = a;
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_err++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_res(input string tag);
    chk(4'hA, m_res[15:0], tag);
    chk(4'hC, m_res[31:16], tag);
    chk(4'hE, exp_ext(), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_opa = 0; m_opb = 0; m_mode = 0; m_res = 0; m_acc = 0; m_carry = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state, every register zero
    for (int i = 0; i < 8; i++) chk(4'(2 * i), 16'h0000, "R11");

    // R3: unsigned multiply, largest operands
    wr(4'h0, 16'hFFFF); wr(4'h8, 16'hFFFF);
    chk(4'hA, 16'h0001, "R3"); chk(4'hC, 16'hFFFE, "R3"); chk(4'hE, 16'h0000, "R3");

    // R4: signed multiply, negative and positive products
    wr(4'h2, 16'hFFFF); wr(4'h8, 16'h0001);
    chk(4'hA, 16'hFFFF, "R4"); chk(4'hC, 16'hFFFF, "R4"); chk(4'hE, 16'hFFFF, "R4");
    wr(4'h2, 16'h8000); wr(4'h8, 16'h8000);
    chk(4'hA, 16'h0000, "R4"); chk(4'hC, 16'h4000, "R4"); chk(4'hE, 16'h0000, "R4");

    // R2: operand B via odd byte address, address bit 0 ignored
    wr(4'h0, 16'h0003); wr(4'h9, 16'h0007);
    chk(4'hA, 16'h0015, "R2"); chk(4'h8, 16'h0007, "R2");

    // R6: unsigned accumulate, carry out of bit 31 and its clearing
    wr(4'h4, 16'hFFFF); wr(4'hA, 16'h0000);
    wr(4'h8, 16'hFFFF);
    chk(4'hC, 16'hFFFE, "R6"); chk(4'hE, 16'h0000, "R6");
    wr(4'h8, 16'hFFFF);
    chk(4'hA, 16'h0002, "R6"); chk(4'hC, 16'hFFFC, "R6"); chk(4'hE, 16'h0001, "R6");
    wr(4'h8, 16'h0001);
    chk(4'hA, 16'h0001, "R6"); chk(4'hC, 16'hFFFD, "R6"); chk(4'hE, 16'h0000, "R6");

    // R5: plain multiply clears the accumulator
    wr(4'h6, 16'h0003); wr(4'hA, 16'h0100); wr(4'h8, 16'h0002);
    chk(4'hA, 16'h0106, "R7");
    wr(4'h2, 16'h0005); wr(4'h8, 16'h0004);
    chk(4'hA, 16'h0014, "R5");
    wr(4'h6, 16'h0003); wr(4'h8, 16'h0002);
    chk(4'hA, 16'h0006, "R5"); chk(4'hC, 16'h0000, "R5");

    // R7: signed accumulate going negative
    wr(4'h6, 16'hFFFE); wr(4'h8, 16'h0005);
    chk(4'hA, 16'hFFFC, "R7"); chk(4'hC, 16'hFFFF, "R7"); chk(4'hE, 16'hFFFF, "R7");

    // R8: preload extension follows the mode
    wr(4'h6, 16'h0000); wr(4'hA, 16'h8000);
    chk(4'hA, 16'h8000, "R8"); chk(4'hC, 16'hFFFF, "R8");
    wr(4'h4, 16'h0001); wr(4'hA, 16'h8000);
    chk(4'hC, 16'h0000, "R8");
    wr(4'h8, 16'h0000);
    chk(4'hA, 16'h8000, "R8"); chk(4'hC, 16'h0000, "R8");

    // R10: writes to high word and extension word are ignored
    wr(4'hC, 16'h1234); wr(4'hE, 16'h5678);
    chk(4'hA, 16'h8000, "R10"); chk(4'hC, 16'h0000, "R10"); chk(4'hE, 16'h0000, "R10");

    // R9: operand read-back; R1: mode taken from address
    wr(4'h2, 16'hABCD);
    for (int i = 0; i < 4; i++) chk(4'(2 * i), 16'hABCD, "R9");
    wr(4'h8, 16'h1357);
    chk(4'h8, 16'h1357, "R9");
    chk(4'hE, exp_ext(), "R1");

    // Random mix across all modes with occasional preloads
    for (int it = 0; it < 400; it++) begin
      logic [1:0]  md;
      logic [15:0] a, b;
      int r;
      r = int'($urandom % 10);
      md = 2'($urandom);
      a = 16'($urandom);
      b = 16'($urandom);
      if (r == 0) a = 16'hFFFF;
      if (r == 1) b = 16'h8000;
      if (r == 9) begin
        wr({1'b0, md, 1'b0}, a);
        wr(4'hA, b);
        chk_res("R8");
      end else begin
        wr({1'b0, md, 1'b0}, a);
        wr(4'h8, b);
        case (md)
          2'd0: chk_res("R3");
          2'd1: chk_res("R4");
          2'd2: chk_res("R6");
          default: chk_res("R7");
        endcase
        chk(4'h0, a, "R9");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule